// File: doc/BRIEF.md
# Programmable Dual-Rate Clock-Enable Divider

This block takes one fast reference clock and derives two single-cycle enable strobes from it. The system-rate strobe paces all peripheral-side logic. The core-rate strobe paces only processor-side logic. Neither output is a generated clock. Each output is a pulse, one reference cycle wide, that downstream flops use as a clock enable.

Two write ports set the ratios. A 4-bit system field selects any integer ratio from 1 to 15. A 2-bit core field selects a power-of-two ratio. Either field can be rewritten while the block runs, and there is no settling or relock delay. A new value is held in a shadow register and takes effect only when the running period of that channel ends. No period is ever cut short or stretched. A system value of zero is rejected and raises a sticky error flag.

Top module: `dual_rate_divider`

## Requirements
- R1: After reset both active ratios are 1, so `sys_en_o` and `core_en_o` are high in every cycle, and `pending_o` and `err_o` are low.
- R2: With system ratio N (the 4-bit unsigned value written to `sys_div_i`, 1 to 15), `sys_en_o` is high for one cycle once every N cycles. In particular, 1, 6 and 10 give periods of 1, 6 and 10.
- R3: The core code written to `core_div_i` selects the `core_en_o` period as code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8 cycles, with one high cycle per period.
- R4: A ratio written during a period does not alter that period. The period that ends with the next enable pulse of that channel keeps the old length, and the following period uses the new ratio.
- R5: `pending_o` is high from the cycle after an accepted write until that write has been applied at a period boundary of its channel. After that it is low, as long as no write is outstanding on either channel.
- R6: Writing 0 to the system field is ignored. The system ratio is unchanged and `pending_o` does not rise, but `err_o` goes high in the next cycle.
- R7: `err_o` stays high until reset, even after later valid writes.
- R8: The two channels are independent. Rewriting one ratio does not change the period of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_wr_i | input | 1 | Write strobe for the system ratio |
| sys_div_i | input | 4 | System ratio, 1 to 15 (0 rejected) |
| core_wr_i | input | 1 | Write strobe for the core ratio code |
| core_div_i | input | 2 | Core ratio code, period 2^code |
| sys_en_o | output | 1 | System-rate enable pulse |
| core_en_o | output | 1 | Core-rate enable pulse |
| pending_o | output | 1 | A written ratio is waiting for its period boundary |
| err_o | output | 1 | Sticky flag: zero was written to the system field |

## Verification
The hardest case to reach is a ratio write that lands in the middle of a running period. In that case the old period must finish at full length before the new one starts. The stimulus first locks onto an enable pulse of a divide-by-6 period. It counts reference cycles from that pulse and issues the write two cycles in. It then measures both the interrupted period and the one after it. The zero-write case is reached the same way, and is followed by a period measurement that shows the old ratio survived.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;
  localparam int unsigned SYS_FIELD_W  = 4;
  localparam int unsigned CORE_CODE_W  = 2;
  localparam int unsigned CORE_RATIO_W = (1 << CORE_CODE_W);
  localparam int unsigned NUM_CH       = 2;
  localparam int unsigned CH_SYS       = 0;
  localparam int unsigned CH_CORE      = 1;
endpackage

// File: rtl/rate_counter.sv
module rate_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == ratio_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  a_r2_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);
  a_r6_ratio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_i != '0);
endmodule

// File: rtl/ratio_shadow.sv
module ratio_shadow #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] val_i,
  input  logic         wrap_i,
  output logic [W-1:0] active_o,
  output logic         pending_o
);
  logic [W-1:0] pend_val_q;
  logic         pend_q;

  // apply only on wrap; a write in the wrap cycle waits for the next wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= W'(1);
      pend_val_q <= W'(1);
      pend_q     <= 1'b0;
    end else begin
      if (wrap_i && pend_q) active_o <= pend_val_q;
      if (wr_i) begin
        pend_val_q <= val_i;
        pend_q     <= 1'b1;
      end else if (wrap_i) begin
        pend_q     <= 1'b0;
      end
    end
  end

  assign pending_o = pend_q;

  a_r4_apply_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(active_o));
  a_r5_pending_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o);
  a_r5_pending_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && wrap_i && !wr_i) |=> !pending_o);
endmodule

// File: rtl/dual_rate_divider.sv
module dual_rate_divider
  import dual_div_pkg::*;
#(
  parameter int unsigned SYS_W  = SYS_FIELD_W,
  parameter int unsigned CODE_W = CORE_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_wr_i,
  input  logic [SYS_W-1:0]  sys_div_i,
  input  logic              core_wr_i,
  input  logic [CODE_W-1:0] core_div_i,
  output logic              sys_en_o,
  output logic              core_en_o,
  output logic              pending_o,
  output logic              err_o
);
  localparam int unsigned CORE_W = (1 << CODE_W);
  localparam int unsigned RW     = (SYS_W > CORE_W) ? SYS_W : CORE_W;

  logic [NUM_CH-1:0]         wr;
  logic [NUM_CH-1:0][RW-1:0] wval;
  logic [NUM_CH-1:0][RW-1:0] ratio;
  logic [NUM_CH-1:0]         tick;
  logic [NUM_CH-1:0]         pend;
  logic                      sys_zero;
  logic                      err_q;

  assign sys_zero      = sys_wr_i && (sys_div_i == '0);
  assign wr[CH_SYS]    = sys_wr_i && !sys_zero;
  assign wval[CH_SYS]  = RW'(sys_div_i);
  assign wr[CH_CORE]   = core_wr_i;
  assign wval[CH_CORE] = RW'(1) << core_div_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ratio_shadow #(.W(RW)) u_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr[c]),
      .val_i    (wval[c]),
      .wrap_i   (tick[c]),
      .active_o (ratio[c]),
      .pending_o(pend[c])
    );
    rate_counter #(.W(RW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ratio_i(ratio[c]),
      .tick_o (tick[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (sys_zero) err_q <= 1'b1;
  end

  assign sys_en_o  = tick[CH_SYS];
  assign core_en_o = tick[CH_CORE];
  assign pending_o = |pend;
  assign err_o     = err_q;

  a_r3_core_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ratio[CH_CORE]));
  a_r6_zero_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_wr_i && sys_div_i == '0) |=> err_o);
  a_r6_zero_no_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_wr_i && sys_div_i == '0 && !pend[CH_SYS]) |=> !pend[CH_SYS]);
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/dual_rate_divider_test.sv
module dual_rate_divider_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sys_wr_i = 1'b0;
  logic [3:0] sys_div_i = '0;
  logic       core_wr_i = 1'b0;
  logic [1:0] core_div_i = '0;
  logic       sys_en_o, core_en_o, pending_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_rate_divider uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sys_wr_i(sys_wr_i), .sys_div_i(sys_div_i),
    .core_wr_i(core_wr_i), .core_div_i(core_div_i),
    .sys_en_o(sys_en_o), .core_en_o(core_en_o),
    .pending_o(pending_o), .err_o(err_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_sys();
    do @(negedge clk_i); while (!sys_en_o);
  endtask

  task automatic sync_core();
    do @(negedge clk_i); while (!core_en_o);
  endtask

  // called at a negedge that shows a pulse; returns cycles to the next pulse
  task automatic sys_period(output int p);
    p = 0;
    do begin @(negedge clk_i); p++; end while (!sys_en_o && p < 64);
  endtask

  task automatic core_period(output int p);
    p = 0;
    do begin @(negedge clk_i); p++; end while (!core_en_o && p < 64);
  endtask

  task automatic wait_applied();
    do @(negedge clk_i); while (pending_o);
  endtask

  task automatic write_sys(input logic [3:0] v);
    @(negedge clk_i);
    sys_wr_i = 1'b1; sys_div_i = v;
    @(negedge clk_i);
    sys_wr_i = 1'b0;
  endtask

  task automatic write_core(input logic [1:0] v);
    @(negedge clk_i);
    core_wr_i = 1'b1; core_div_i = v;
    @(negedge clk_i);
    core_wr_i = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk_i);
    check("R1 sys_en", int'(sys_en_o), 1);
    check("R1 core_en", int'(core_en_o), 1);
    check("R1 pending", int'(pending_o), 0);
    check("R1 err", int'(err_o), 0);
    @(negedge clk_i);
    check("R1 sys_en every cycle", int'(sys_en_o), 1);
    check("R1 core_en every cycle", int'(core_en_o), 1);
  endtask

  task automatic test_sys_ratios();
    int p;
    foreach (sys_ratio_list[i]) begin
      write_sys(sys_ratio_list[i]);
      wait_applied();
      sync_sys();
      sys_period(p);
      check($sformatf("R2 sys period ratio %0d", sys_ratio_list[i]), p, int'(sys_ratio_list[i]));
      sys_period(p);
      check($sformatf("R2 sys period repeat ratio %0d", sys_ratio_list[i]), p, int'(sys_ratio_list[i]));
    end
  endtask

  task automatic test_core_codes();
    int p;
    for (int c = 3; c >= 0; c--) begin
      write_core(2'(c));
      wait_applied();
      sync_core();
      core_period(p);
      check($sformatf("R3 core period code %0d", c), p, 1 << c);
    end
  endtask

  task automatic test_boundary_switch();
    int p;
    write_sys(4'd6);
    wait_applied();
    sync_sys();
    p = 0;
    @(negedge clk_i); p++;
    @(negedge clk_i); p++;
    sys_wr_i = 1'b1; sys_div_i = 4'd10;
    @(negedge clk_i); p++;
    sys_wr_i = 1'b0;
    check("R5 pending after write", int'(pending_o), 1);
    while (!sys_en_o && p < 64) begin @(negedge clk_i); p++; end
    check("R4 interrupted period keeps old ratio", p, 6);
    check("R5 pending until boundary", int'(pending_o), 1);
    @(negedge clk_i);
    check("R5 pending cleared after boundary", int'(pending_o), 0);
    p = 1;
    while (!sys_en_o && p < 64) begin @(negedge clk_i); p++; end
    check("R4 next period uses new ratio", p, 10);
  endtask

  task automatic test_zero();
    int p;
    write_sys(4'd6);
    wait_applied();
    write_sys(4'd0);
    check("R6 err raised", int'(err_o), 1);
    check("R6 no pending", int'(pending_o), 0);
    sync_sys();
    sys_period(p);
    check("R6 ratio unchanged", p, 6);
    write_sys(4'd3);
    wait_applied();
    sync_sys();
    sys_period(p);
    check("R7 valid write after zero", p, 3);
    check("R7 err sticky", int'(err_o), 1);
  endtask

  task automatic test_independent();
    int p;
    write_sys(4'd6);
    write_core(2'd3);
    wait_applied();
    sync_core();
    core_period(p);
    check("R8 core period 8", p, 8);
    write_core(2'd1);
    wait_applied();
    sync_sys();
    sys_period(p);
    check("R8 sys unchanged after core write", p, 6);
    sync_core();
    core_period(p);
    check("R8 core period 2", p, 2);
    write_sys(4'd15);
    wait_applied();
    sync_core();
    core_period(p);
    check("R8 core unchanged after sys write", p, 2);
    sync_sys();
    sys_period(p);
    check("R2 sys period 15", p, 15);
  endtask

  logic [3:0] sys_ratio_list [4] = '{4'd1, 4'd6, 4'd10, 4'd15};

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    test_reset();
    test_sys_ratios();
    test_core_codes();
    test_boundary_switch();
    test_zero();
    test_independent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule